// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM that is 8 bits wide with a 17-bit address. The host offers one transfer at a time on a valid/ready handshake carrying an address, a write flag and a write byte. The controller turns each transfer into a properly timed pattern of two chip selects of opposite polarity, an active-low output enable and an active-low write enable. Read data comes back to the host together with a one-cycle valid pulse.

All RAM timing minimums are fixed by a speed-grade parameter, either the 55 ns set or the 70 ns set. They are turned into whole clock cycles using a clock-period parameter. Every strobe leaves the block from a flop. The controller drives the RAM data pins only through a separate output-enable signal. Between transfers both chip selects are released, so the RAM stays in standby. When a write comes right after a read, the controller waits for the RAM to let go of the bus before it drives the data pins.

Top module: `sram_ctrl`

## Requirements
- R1: While the controller is idle, req_ready is 1, mem_cs_n is 1, mem_cs is 0, mem_oe_n is 1, mem_we_n is 1 and mem_dq_oe is 0. The same holds out of reset.
- R2: A read holds mem_cs_n=0, mem_cs=1, mem_we_n=1 and mem_oe_n=0 for exactly R cycles. R is the larger of ceil(address access/T) and ceil(output-enable access/T). mem_addr equals the accepted address whenever mem_cs_n is 0.
- R3: rd_data equals mem_dq_i as sampled on the clock edge that ends the last mem_oe_n-low cycle. rd_valid is 1 for exactly one cycle, the cycle right after that edge.
- R4: A write holds mem_we_n low for exactly W cycles. W = max(ceil(max(write pulse, data setup, address-to-end)/T), ceil(write cycle/T) - 1). One further cycle follows with mem_we_n=1 and the chip still selected, so the whole write takes W+1 cycles and is never shorter than the write-cycle minimum.
- R5: mem_dq_oe is 1 only from the first mem_we_n-low cycle through the closing cycle that follows it. During that span mem_dq_o holds the accepted write byte without change.
- R6: When a write follows a read, mem_dq_oe does not rise until mem_oe_n has been high for at least TA = ceil(output float time/T) cycles. If the write is accepted in the first idle cycle after the read, exactly TA cycles separate the two.
- R7: mem_we_n and mem_oe_n are never low in the same cycle. mem_oe_n is low only while the chip is selected and mem_we_n is 1.
- R8: With GRADE_SLOW=0 the block uses 45/55/45/45 ns for write pulse/write cycle/data setup/address-to-end, 55/25 ns for address/output-enable access, and 20 ns float. With GRADE_SLOW=1 these become 50/70/55/60, 70/35 and 25 ns.
- R9: A request is taken only when req_valid and req_ready are both 1. req_ready is 0 in the cycle after a request is taken and stays 0 until the transfer is over.
- R10: Each derived cycle count is at least 1. With a 100 ns clock period, both grades give W=R=TA=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host offers a transfer |
| req_ready | output | 1 | Controller idle and able to take a transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write byte |
| rd_valid | output | 1 | One-cycle pulse marking rd_data valid |
| rd_data | output | DW | Captured read byte |
| mem_addr | output | AW | RAM address pins |
| mem_dq_o | output | DW | Byte driven toward the RAM data pins |
| mem_dq_i | input | DW | Byte seen on the RAM data pins |
| mem_dq_oe | output | 1 | Enables the controller's data-pin drivers |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low RAM output enable |
| mem_we_n | output | 1 | Active-low RAM write enable |

## Verification
The bench runs the controller in four configurations: both speed grades at 10 ns, the slow grade at a 7 ns period where the rounding matters, and a 100 ns period where every count falls to one cycle. In each configuration it measures the strobe widths and compares them against counts it derives itself. The RAM model returns garbage until the expected access time has passed, so a controller that samples read data one cycle early picks up the wrong byte. A write issued in the first idle cycle after a read must show exactly the float gap: if the gap is dropped, the driver turns on while the RAM still holds the bus, and if it is doubled, every read-then-write pair wastes cycles. The write sweep confirms that data stays driven through the closing cycle, since a controller that releases the pins at the rising edge of the write enable would store a corrupted byte in the model.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TURN = 3'd1,
    ST_WR   = 3'd2,
    ST_WEND = 3'd3,
    ST_RD   = 3'd4
  } ctl_st_e;

  typedef enum int unsigned {
    TM_WE_PULSE,
    TM_WR_CYCLE,
    TM_DATA_SETUP,
    TM_ADDR_TO_END,
    TM_ADDR_ACCESS,
    TM_OE_ACCESS,
    TM_OE_FLOAT
  } tm_sel_e;

  // Timing minimums in ns for the two speed grades
  function automatic int unsigned tm_ns(input bit slow, input tm_sel_e sel);
    case (sel)
      TM_WE_PULSE:    return slow ? 50 : 45;
      TM_WR_CYCLE:    return slow ? 70 : 55;
      TM_DATA_SETUP:  return slow ? 55 : 45;
      TM_ADDR_TO_END: return slow ? 60 : 45;
      TM_ADDR_ACCESS: return slow ? 70 : 55;
      TM_OE_ACCESS:   return slow ? 35 : 25;
      default:        return slow ? 25 : 20;
    endcase
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Round up to whole cycles, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned wr_low_cyc(input bit slow, input int unsigned per);
    int unsigned strobe;
    int unsigned whole;
    strobe = ns_to_cyc(max2(max2(tm_ns(slow, TM_WE_PULSE), tm_ns(slow, TM_DATA_SETUP)),
                            tm_ns(slow, TM_ADDR_TO_END)), per);
    whole  = ns_to_cyc(tm_ns(slow, TM_WR_CYCLE), per);
    return max2(strobe, whole - 1);
  endfunction

  function automatic int unsigned rd_cyc(input bit slow, input int unsigned per);
    return max2(ns_to_cyc(tm_ns(slow, TM_ADDR_ACCESS), per),
                ns_to_cyc(tm_ns(slow, TM_OE_ACCESS), per));
  endfunction

  function automatic int unsigned turn_cyc(input bit slow, input int unsigned per);
    return ns_to_cyc(tm_ns(slow, TM_OE_FLOAT), per);
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero_q,
  output logic          zero_d
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          upd;

  always_comb begin
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  assign upd    = load || (cnt_q != '0);
  assign zero_q = (cnt_q == '0);
  assign zero_d = (cnt_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (upd) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned W_CYC = 5,
  parameter int unsigned R_CYC = 6,
  parameter int unsigned CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          ph_zero,
  input  logic          flt_zero_d,
  output logic          req_ready,
  output logic          accept,
  output logic          ph_load,
  output logic [CW-1:0] ph_val,
  output logic          flt_load,
  output logic          capture,
  output logic          cs_n,
  output logic          cs,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe
);

  localparam logic [CW-1:0] W_LD = CW'(W_CYC - 1);
  localparam logic [CW-1:0] R_LD = CW'(R_CYC - 1);

  ctl_st_e st_q;
  ctl_st_e st_d;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign capture   = (st_q == ST_RD) && ph_zero;
  assign flt_load  = capture;

  always_comb begin
    st_d    = st_q;
    ph_load = 1'b0;
    ph_val  = W_LD;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_write) begin
            if (flt_zero_d) begin
              st_d    = ST_WR;
              ph_load = 1'b1;
            end else begin
              st_d = ST_TURN;
            end
          end else begin
            st_d    = ST_RD;
            ph_load = 1'b1;
            ph_val  = R_LD;
          end
        end
      end
      ST_TURN: begin
        if (flt_zero_d) begin
          st_d    = ST_WR;
          ph_load = 1'b1;
        end
      end
      ST_WR: begin
        if (ph_zero) begin
          st_d = ST_WEND;
        end
      end
      ST_WEND: st_d = ST_IDLE;
      ST_RD: begin
        if (ph_zero) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Strobes come straight from flops, decoded from the next state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cs_n  <= 1'b1;
      cs    <= 1'b0;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      st_q  <= st_d;
      cs_n  <= (st_d == ST_IDLE);
      cs    <= (st_d != ST_IDLE);
      oe_n  <= (st_d != ST_RD);
      we_n  <= (st_d != ST_WR);
      dq_oe <= (st_d == ST_WR) || (st_d == ST_WEND);
    end
  end

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      dq_o     <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      dq_o     <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (capture) begin
      rd_data <= dq_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= capture;
    end
  end

endmodule

// File: rtl/sram_ctrl_rst_sync.sv
module sram_ctrl_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      meta_q    <= 1'b0;
      rst_out_n <= 1'b0;
    end else begin
      meta_q    <= 1'b1;
      rst_out_n <= meta_q;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW            = 17,
  parameter int unsigned DW            = 8,
  parameter bit          GRADE_SLOW    = 1'b0,
  parameter int unsigned CLK_PERIOD_NS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_dq_oe,
  output logic          mem_cs_n,
  output logic          mem_cs,
  output logic          mem_oe_n,
  output logic          mem_we_n
);

  localparam int unsigned W_CYC   = wr_low_cyc(GRADE_SLOW, CLK_PERIOD_NS);
  localparam int unsigned R_CYC   = rd_cyc(GRADE_SLOW, CLK_PERIOD_NS);
  localparam int unsigned TA_CYC  = turn_cyc(GRADE_SLOW, CLK_PERIOD_NS);
  localparam int unsigned CNT_MAX = max2(max2(W_CYC, R_CYC), TA_CYC);
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  logic          rst_sync_n;
  logic          accept;
  logic          ph_load;
  logic [CW-1:0] ph_val;
  logic          ph_zero;
  logic          ph_zero_d;
  logic          flt_load;
  logic          flt_zero_q;
  logic          flt_zero_d;
  logic          capture;

  sram_ctrl_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  sram_ctrl_timer #(.CW(CW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (ph_load),
    .load_val (ph_val),
    .zero_q   (ph_zero),
    .zero_d   (ph_zero_d)
  );

  sram_ctrl_timer #(.CW(CW)) u_float (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (flt_load),
    .load_val (CW'(TA_CYC)),
    .zero_q   (flt_zero_q),
    .zero_d   (flt_zero_d)
  );

  sram_ctrl_fsm #(
    .W_CYC (W_CYC),
    .R_CYC (R_CYC),
    .CW    (CW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .ph_zero    (ph_zero),
    .flt_zero_d (flt_zero_d),
    .req_ready  (req_ready),
    .accept     (accept),
    .ph_load    (ph_load),
    .ph_val     (ph_val),
    .flt_load   (flt_load),
    .capture    (capture),
    .cs_n       (mem_cs_n),
    .cs         (mem_cs),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .dq_oe      (mem_dq_oe)
  );

  sram_ctrl_dpath #(
    .AW (AW),
    .DW (DW)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .dq_i      (mem_dq_i),
    .mem_addr  (mem_addr),
    .dq_o      (mem_dq_o),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  // Zero flags not needed by the sequencer are tied off into a local sink
  logic unused_flags;
  assign unused_flags = ph_zero_d ^ flt_zero_q;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW            = 17,
  parameter int unsigned DW            = 8,
  parameter bit          GRADE_SLOW    = 1'b0,
  parameter int unsigned CLK_PERIOD_NS = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rd_valid,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_o,
  input logic          mem_dq_oe,
  input logic          mem_cs_n,
  input logic          mem_cs,
  input logic          mem_oe_n,
  input logic          mem_we_n
);

  localparam int unsigned W_CHK  = wr_low_cyc(GRADE_SLOW, CLK_PERIOD_NS);
  localparam int unsigned R_CHK  = rd_cyc(GRADE_SLOW, CLK_PERIOD_NS);
  localparam int unsigned TA_CHK = turn_cyc(GRADE_SLOW, CLK_PERIOD_NS);

  int unsigned we_low_cnt;
  int unsigned oe_low_cnt;
  int unsigned oe_high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt  <= 0;
      oe_low_cnt  <= 0;
      oe_high_cnt <= TA_CHK;
    end else begin
      we_low_cnt  <= !mem_we_n ? we_low_cnt + 1 : 0;
      oe_low_cnt  <= !mem_oe_n ? oe_low_cnt + 1 : 0;
      if (!mem_oe_n) begin
        oe_high_cnt <= 0;
      end else if (oe_high_cnt < TA_CHK) begin
        oe_high_cnt <= oe_high_cnt + 1;
      end
    end
  end

  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe));

  // R2
  rd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_low_cnt == R_CHK));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  // R3
  rv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R4
  we_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == W_CHK && !mem_cs_n && mem_cs));

  // R5
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_cs_n && mem_cs && mem_oe_n));

  // R5
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_o));

  // R6
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_high_cnt >= TA_CHK));

  // R7
  no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n && mem_cs));

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .AW            (AW),
  .DW            (DW),
  .GRADE_SLOW    (GRADE_SLOW),
  .CLK_PERIOD_NS (CLK_PERIOD_NS)
) u_sram_ctrl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .mem_addr  (mem_addr),
  .mem_dq_o  (mem_dq_o),
  .mem_dq_oe (mem_dq_oe),
  .mem_cs_n  (mem_cs_n),
  .mem_cs    (mem_cs),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n)
);

// File: tb/sram_ctrl_harness.sv
module sram_ctrl_harness #(
  parameter bit GRADE_SLOW = 1'b0,
  parameter int PERIOD_NS  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done,
  output int   checks,
  output int   errors
);

  function automatic int cdiv1(input int a, input int b);
    int c;
    c = (a + b - 1) / b;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected counts derived from the R8 timing sets
  localparam int NS_WP = GRADE_SLOW ? 50 : 45;
  localparam int NS_WC = GRADE_SLOW ? 70 : 55;
  localparam int NS_SD = GRADE_SLOW ? 55 : 45;
  localparam int NS_AW = GRADE_SLOW ? 60 : 45;
  localparam int NS_AA = GRADE_SLOW ? 70 : 55;
  localparam int NS_OA = GRADE_SLOW ? 35 : 25;
  localparam int NS_HZ = GRADE_SLOW ? 25 : 20;
  localparam int W_EXP  = imax(cdiv1(imax(imax(NS_WP, NS_SD), NS_AW), PERIOD_NS),
                               cdiv1(NS_WC, PERIOD_NS) - 1);
  localparam int WC_EXP = cdiv1(NS_WC, PERIOD_NS);
  localparam int R_EXP  = imax(cdiv1(NS_AA, PERIOD_NS), cdiv1(NS_OA, PERIOD_NS));
  localparam int TA_EXP = cdiv1(NS_HZ, PERIOD_NS);
  localparam string CFG = (PERIOD_NS >= 100) ? "R10" : "R8";

  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i;
  logic        mem_dq_oe;
  logic        mem_cs_n;
  logic        mem_cs;
  logic        mem_oe_n;
  logic        mem_we_n;

  sram_ctrl #(
    .AW            (17),
    .DW            (8),
    .GRADE_SLOW    (GRADE_SLOW),
    .CLK_PERIOD_NS (PERIOD_NS)
  ) u_sram_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_i  (mem_dq_i),
    .mem_dq_oe (mem_dq_oe),
    .mem_cs_n  (mem_cs_n),
    .mem_cs    (mem_cs),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n)
  );

  // RAM model: small array, data only valid once the access time has run
  logic [7:0]  mem [256];
  int          oe_run, oe_len, we_run, we_len, hi_run, gap;
  int          ovl, rv_total, addr_bad, data_bad;
  logic [7:0]  dq_prev;
  logic        dq_oe_prev;
  logic [16:0] cur_addr;

  assign mem_dq_i = (!mem_oe_n && mem_we_n && !mem_cs_n && mem_cs && oe_run >= R_EXP - 1)
                    ? mem[mem_addr[7:0]] : 8'h55;

  always @(posedge clk) begin
    if (!rst_n) begin
      oe_run <= 0; oe_len <= 0; we_run <= 0; we_len <= 0;
      hi_run <= 255; gap <= 0; ovl <= 0; rv_total <= 0;
      addr_bad <= 0; data_bad <= 0; dq_prev <= 8'h00; dq_oe_prev <= 1'b0;
    end else begin
      if (!mem_oe_n) begin
        oe_run <= oe_run + 1;
        oe_len <= oe_run + 1;
      end else begin
        oe_run <= 0;
      end
      if (!mem_we_n) begin
        we_run <= we_run + 1;
        we_len <= we_run + 1;
        if (!mem_dq_oe || (we_run != 0 && mem_dq_o != dq_prev)) data_bad <= data_bad + 1;
      end else begin
        if (we_run != 0) begin
          mem[mem_addr[7:0]] <= mem_dq_o;
          if (!mem_dq_oe || mem_cs_n || !mem_cs) data_bad <= data_bad + 1;
        end
        we_run <= 0;
      end
      dq_prev <= mem_dq_o;
      if (!mem_oe_n) hi_run <= 0;
      else if (hi_run < 255) hi_run <= hi_run + 1;
      if (mem_dq_oe && !dq_oe_prev) gap <= hi_run;
      dq_oe_prev <= mem_dq_oe;
      if (!mem_we_n && !mem_oe_n) ovl <= ovl + 1;
      if (rd_valid) rv_total <= rv_total + 1;
      if (!mem_cs_n && mem_addr != cur_addr) addr_bad <= addr_bad + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL g%0d p%0d %s: got %0d expected %0d", GRADE_SLOW, PERIOD_NS, tag, act, exp);
    end
  endtask

  task automatic chk_standby(input string tag);
    chk(req_ready && mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe, tag,
        {27'd0, req_ready, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe}, 6'b110110);
  endtask

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    cur_addr  = a;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 busy after accept", int'(req_ready), 0);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    issue(1'b1, a, d);
    while (!req_ready) @(negedge clk);
    chk(we_len == W_EXP, {"R4 ", CFG, " we_n low cycles"}, we_len, W_EXP);
    chk(we_len + 1 >= WC_EXP, "R4 whole write cycle", we_len + 1, WC_EXP);
    chk(mem[a[7:0]] == d, "R5 byte stored", int'(mem[a[7:0]]), int'(d));
    chk_standby("R1 idle after write");
  endtask

  task automatic do_read(input logic [16:0] a, input logic [7:0] exp_d);
    issue(1'b0, a, 8'h00);
    while (!rd_valid) @(negedge clk);
    chk(rd_data == exp_d, "R3 read data", int'(rd_data), int'(exp_d));
    chk(oe_len == R_EXP, {"R2 ", CFG, " oe_n low cycles"}, oe_len, R_EXP);
    chk_standby("R1 idle after read");
  endtask

  function automatic logic [16:0] addr_of(input int a);
    return 17'h1A300 | 17'(a);
  endfunction

  function automatic logic [7:0] data_of(input int a);
    return {~a[3:0], a[3:0]};
  endfunction

  int reads;

  initial begin
    done      = 1'b0;
    checks    = 0;
    errors    = 0;
    reads     = 0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    cur_addr  = '0;
    wait (start);
    @(negedge clk);
    chk_standby("R1 reset state");
    for (int a = 0; a < 16; a++) do_write(addr_of(a), data_of(a));
    for (int a = 0; a < 16; a++) begin
      do_read(addr_of(a), data_of(a));
      reads++;
    end
    // R6: write issued in the first idle cycle after a read
    for (int a = 0; a < 4; a++) begin
      do_read(addr_of(a), data_of(a));
      reads++;
      do_write(addr_of(a + 16), 8'(8'h30 + a));
      chk(gap == TA_EXP, "R6 float gap before drive", gap, TA_EXP);
      do_read(addr_of(a + 16), 8'(8'h30 + a));
      reads++;
    end
    @(negedge clk);
    chk(ovl == 0, "R7 oe_n/we_n overlap cycles", ovl, 0);
    chk(rv_total == reads, "R3 rd_valid pulses", rv_total, reads);
    chk(addr_bad == 0, "R2 address held while selected", addr_bad, 0);
    chk(data_bad == 0, "R5 data drive window", data_bad, 0);
    chk(W_EXP >= 1 && R_EXP >= 1 && TA_EXP >= 1, "R10 counts at least one", W_EXP, 1);
    done = 1'b1;
  end

endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk;
  logic rst_n;
  logic start;
  logic done0, done1, done2, done3;
  int   chk0, chk1, chk2, chk3;
  int   err0, err1, err2, err3;
  int   cyc;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  sram_ctrl_harness #(.GRADE_SLOW(1'b0), .PERIOD_NS(10)) u_fast (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done0), .checks(chk0), .errors(err0));
  sram_ctrl_harness #(.GRADE_SLOW(1'b1), .PERIOD_NS(10)) u_slow (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done1), .checks(chk1), .errors(err1));
  sram_ctrl_harness #(.GRADE_SLOW(1'b1), .PERIOD_NS(7)) u_odd (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done2), .checks(chk2), .errors(err2));
  sram_ctrl_harness #(.GRADE_SLOW(1'b0), .PERIOD_NS(100)) u_coarse (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done3), .checks(chk3), .errors(err3));

  initial begin
    int total_chk;
    int total_err;
    cyc   = 0;
    rst_n = 1'b0;
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    start = 1'b1;
    wait ((done0 && done1 && done2 && done3) || cyc >= WATCHDOG);
    total_chk = chk0 + chk1 + chk2 + chk3;
    total_err = err0 + err1 + err2 + err3;
    if (!(done0 && done1 && done2 && done3)) begin
      total_chk++;
      total_err++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", total_chk, total_err);
    $finish;
  end

endmodule